// File: doc/BRIEF.md
# Multichannel Digital Zero-Data Detector

This block watches the sample words of six audio channels, one word per channel per sample period, and tells downstream logic when a channel has gone silent. A channel counts as silent once it has delivered an all-zero word in each of `RUN_LEN` consecutive sample periods (1024 by default). Each channel has its own status flag. A global flag reports that every channel is silent at the same time. A single control bit sets whether all flags are active-high or active-low.

A strobe marks each sample period. A channel is "nonzero" when any bit of its word is set, the sign bit included. A second control input marks right-justified serial data. In that format, per-channel detection is not meaningful on its own, so the two lanes of each stereo pair (0/1, 2/3, 4/5) both report the pair's combined state. A pair reads as silent only when both of its lanes have completed their zero runs.

Each lane holds a small state machine with a saturating run counter. The states are:
- `ST_LIVE`: the last sample was nonzero, or the lane has just left reset. The counter is 0.
- `ST_COUNT`: a zero run is in progress. The counter is between 1 and `RUN_LEN`-1.
- `ST_SILENT`: the run has completed and the counter is held at `RUN_LEN`.

The transitions all happen only on a strobe:
- live-to-count: a zero word arrives in `ST_LIVE`.
- count-step: a zero word arrives in `ST_COUNT` below the threshold.
- count-to-silent: the `RUN_LEN`-th consecutive zero word arrives.
- silent-hold: further zero words arrive in `ST_SILENT`.
- any-to-live: a nonzero word arrives in any state.

Top module: `zw_detector`

## Requirements
- R1: A lane's run is complete once it has received an all-zero word on `RUN_LEN` consecutive strobes. Its flag shows active from the clock edge that takes the `RUN_LEN`-th such strobe, and not after any shorter run.
- R2: The run counter saturates. A lane stays complete for any number of further zero strobes and never wraps back to incomplete.
- R3: A strobed word with any bit set, including only the sign bit, restarts that lane's run from zero. Its flag shows inactive from that same clock edge.
- R4: Clock cycles without a strobe change no run state or flag, whatever is on the sample inputs.
- R5: `all_zero` is active exactly when all six lanes have complete runs, in both serial formats.
- R6: With `pol_low`=0 every flag is 1 when active and 0 when inactive. With `pol_low`=1 the levels are inverted. The polarity applies combinationally to all seven outputs.
- R7: With `rj_mode`=1, flags 2k and 2k+1 are each active only when lanes 2k and 2k+1 are both complete. With `rj_mode`=0 each flag follows its own lane. Lane i occupies bits [i*SAMPLE_W +: SAMPLE_W] of `smp_data`.
- R8: A synchronous reset clears every run. While reset is held and after it is released, all flags sit at the inactive level for the selected polarity, and a fresh run of `RUN_LEN` zero words is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-cycle strobe marking a sample period |
| smp_data | input | NUM_CH*SAMPLE_W | Sample words, lane i at bits [i*SAMPLE_W +: SAMPLE_W] |
| rj_mode | input | 1 | 1 = right-justified format, lanes merged in stereo pairs |
| pol_low | input | 1 | 0 = active-high flags, 1 = active-low flags |
| zero_flag | output | NUM_CH | Per-lane (or per-pair) silence flags |
| all_zero | output | 1 | Global silence flag |

## Verification
A lane stuck in the wrong state shows up as a wrong flag level in the very next cycle. The flags are decoded combinationally from the state register, so a run that completes one strobe early or late, or a counter that wraps, changes the flag exactly at the strobe where the bench's arithmetic run count crosses `RUN_LEN`. The bench runs a reduced configuration (`RUN_LEN`=8, 8-bit words). It sweeps every lane through periodic patterns with run lengths below, at and above the threshold, under all four format and polarity combinations, with garbage data between strobes. This way a missed hold, a wrong pair merge or a wrong polarity is visible within one sample period of the cause.

// File: rtl/zw_pkg.sv
package zw_pkg;
    typedef enum logic [1:0] {
        ST_LIVE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_SILENT = 2'd2
    } run_state_t;
endpackage

// File: rtl/zw_run_tracker.sv
module zw_run_tracker
    import zw_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int RUN_LEN  = 1024,
    localparam int CNT_W   = $clog2(RUN_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stb,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                run_done
);

    run_state_t         state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic               is_nz;

    assign is_nz = |sample;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (stb) begin
            if (is_nz) begin
                state_d = ST_LIVE;
                cnt_d   = '0;
            end else begin
                unique case (state_q)
                    ST_LIVE: begin
                        cnt_d   = CNT_W'(1);
                        state_d = (RUN_LEN == 1) ? ST_SILENT : ST_COUNT;
                    end
                    ST_COUNT: begin
                        cnt_d = cnt_q + CNT_W'(1);
                        if (cnt_q == CNT_W'(RUN_LEN - 1))
                            state_d = ST_SILENT;
                    end
                    ST_SILENT: begin
                        state_d = ST_SILENT;
                    end
                    default: begin
                        state_d = ST_LIVE;
                        cnt_d   = '0;
                    end
                endcase
            end
        end
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_SILENT: run_done = 1'b1;
            default:   run_done = 1'b0;
        endcase
    end

    // R2
    cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(RUN_LEN));

    // R3
    nz_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && is_nz) |=> (state_q == ST_LIVE && cnt_q == '0));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stb |=> ($stable(cnt_q) && $stable(state_q)));

    // R1
    silent_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run_done) |-> ($past(stb) && $past(cnt_q) == CNT_W'(RUN_LEN - 1)));

endmodule

// File: rtl/zw_flag_merge.sv
module zw_flag_merge #(
    parameter int NUM_CH = 6,
    localparam int NPAIR = NUM_CH / 2
) (
    input  logic [NUM_CH-1:0] done,
    input  logic              rj_mode,
    input  logic              pol_low,
    output logic [NUM_CH-1:0] zero_flag,
    output logic              all_zero
);

    logic [NUM_CH-1:0] active;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic both;
        assign both = done[2*p] & done[2*p+1];
        assign active[2*p]   = rj_mode ? both : done[2*p];
        assign active[2*p+1] = rj_mode ? both : done[2*p+1];
    end

    if (NUM_CH % 2 == 1) begin : g_odd
        assign active[NUM_CH-1] = done[NUM_CH-1];
    end

    assign zero_flag = active ^ {NUM_CH{pol_low}};
    assign all_zero  = (&done) ^ pol_low;

endmodule

// File: rtl/zw_detector.sv
module zw_detector #(
    parameter int NUM_CH   = 6,
    parameter int SAMPLE_W = 24,
    parameter int RUN_LEN  = 1024,
    localparam int DATA_W  = NUM_CH * SAMPLE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_stb,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              rj_mode,
    input  logic              pol_low,
    output logic [NUM_CH-1:0] zero_flag,
    output logic              all_zero
);

    logic [NUM_CH-1:0] lane_done;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
        zw_run_tracker #(
            .SAMPLE_W (SAMPLE_W),
            .RUN_LEN  (RUN_LEN)
        ) u_trk (
            .clk      (clk),
            .rst      (rst),
            .stb      (smp_stb),
            .sample   (smp_data[i*SAMPLE_W +: SAMPLE_W]),
            .run_done (lane_done[i])
        );
    end

    zw_flag_merge #(
        .NUM_CH (NUM_CH)
    ) u_merge (
        .done      (lane_done),
        .rj_mode   (rj_mode),
        .pol_low   (pol_low),
        .zero_flag (zero_flag),
        .all_zero  (all_zero)
    );

    // R7
    for (genvar p = 0; p < NUM_CH / 2; p++) begin : g_pair_chk
        pair_match_chk: assert property (@(posedge clk) disable iff (rst)
            rj_mode |-> (zero_flag[2*p] == zero_flag[2*p+1]));
    end

    // R5
    global_chk: assert property (@(posedge clk) disable iff (rst)
        (all_zero != pol_low) |-> ((zero_flag ^ {NUM_CH{pol_low}}) == {NUM_CH{1'b1}}));

    // R8
    reset_chk: assert property (@(posedge clk)
        rst |=> (zero_flag == {NUM_CH{pol_low}} && all_zero == pol_low));

endmodule

// File: tb/zw_detector_test.sv
module zw_detector_test;
    localparam int NUM_CH   = 6;
    localparam int SAMPLE_W = 8;
    localparam int RUN_LEN  = 8;
    localparam int DATA_W   = NUM_CH * SAMPLE_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              smp_stb = 1'b0;
    logic [DATA_W-1:0] smp_data = '0;
    logic              rj_mode = 1'b0;
    logic              pol_low = 1'b0;
    logic [NUM_CH-1:0] zero_flag;
    logic              all_zero;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    int run_cnt [NUM_CH];

    always #5 clk = ~clk;

    zw_detector #(
        .NUM_CH   (NUM_CH),
        .SAMPLE_W (SAMPLE_W),
        .RUN_LEN  (RUN_LEN)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .smp_stb   (smp_stb),
        .smp_data  (smp_data),
        .rj_mode   (rj_mode),
        .pol_low   (pol_low),
        .zero_flag (zero_flag),
        .all_zero  (all_zero)
    );

    task automatic check_out(input string tag);
        logic [NUM_CH-1:0] done, exp_f;
        logic exp_a;
        for (int c = 0; c < NUM_CH; c++) done[c] = (run_cnt[c] >= RUN_LEN);
        for (int c = 0; c < NUM_CH; c++)
            exp_f[c] = rj_mode ? (done[c] & done[c ^ 1]) : done[c];
        exp_f = exp_f ^ {NUM_CH{pol_low}};
        exp_a = (&done) ^ pol_low;
        checks++;
        if (zero_flag !== exp_f || all_zero !== exp_a) begin
            fails++;
            $display("FAIL %s: flags=%b all=%b expected flags=%b all=%b",
                     tag, zero_flag, all_zero, exp_f, exp_a);
        end
    endtask

    task automatic strobe(input logic [DATA_W-1:0] d, input string tag);
        @(negedge clk);
        smp_stb  = 1'b1;
        smp_data = d;
        @(negedge clk);
        smp_stb  = 1'b0;
        smp_data = {DATA_W{1'b1}};
        for (int c = 0; c < NUM_CH; c++) begin
            if (d[c*SAMPLE_W +: SAMPLE_W] == '0)
                run_cnt[c] = (run_cnt[c] >= RUN_LEN) ? RUN_LEN : run_cnt[c] + 1;
            else
                run_cnt[c] = 0;
        end
        check_out(tag);
    endtask

    // R4: idle cycles with garbage data, checked every cycle
    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            smp_data = {DATA_W{1'b1}} ^ DATA_W'(k);
            check_out("R4 idle hold");
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        for (int c = 0; c < NUM_CH; c++) run_cnt[c] = 0;
        check_out("R8 reset held");
        rst = 1'b0;
    endtask

    function automatic logic [SAMPLE_W-1:0] nz_val(input int t);
        case (t % 4)
            0: return 8'h01;
            1: return 8'h80;
            2: return 8'hFF;
            default: return 8'h40;
        endcase
    endfunction

    initial begin
        logic [DATA_W-1:0] d;
        int per [NUM_CH];
        per = '{7, 9, 10, 12, 16, 20};
        for (int c = 0; c < NUM_CH; c++) run_cnt[c] = 0;

        // R8 / R6: reset levels under both polarities
        repeat (3) @(negedge clk);
        check_out("R8 reset pol0");
        pol_low = 1'b1;
        #1;
        check_out("R6 R8 reset pol1");
        pol_low = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        // R1 / R2: threshold and saturation
        for (int t = 0; t < 14; t++) strobe('0, "R1 R2 all-zero run");
        idle(3);
        // R3: sign bit only on lane 3
        d = '0;
        d[3*SAMPLE_W +: SAMPLE_W] = 8'h80;
        strobe(d, "R3 sign-bit clear");
        // R6: polarity flip while flags are mixed
        @(negedge clk);
        pol_low = 1'b1;
        #1;
        check_out("R6 polarity flip");
        pol_low = 1'b0;
        strobe({DATA_W{1'b1}}, "R3 all nonzero");

        // Sweep: periodic patterns, all format/polarity combinations
        for (int m = 0; m < 4; m++) begin
            rj_mode = m[0];
            pol_low = m[1];
            for (int t = 0; t < 160; t++) begin
                d = '0;
                for (int c = 0; c < NUM_CH; c++)
                    if ((t + 5 * c) % per[c] == 0)
                        d[c*SAMPLE_W +: SAMPLE_W] = nz_val(t + c);
                strobe(d, rj_mode ? "R7 R1 R3 sweep rj" : "R1 R3 R6 sweep");
                if (t % 7 == 3) idle(2);
            end
        end

        // R5 / R7: break one lane at a time from the all-silent state
        for (int m = 0; m < 2; m++) begin
            rj_mode = m[0];
            pol_low = 1'b0;
            for (int c = 0; c < NUM_CH; c++) begin
                for (int t = 0; t < RUN_LEN + 1; t++) strobe('0, "R5 global build");
                d = '0;
                d[c*SAMPLE_W +: SAMPLE_W] = nz_val(c);
                strobe(d, "R5 R7 single lane break");
                for (int t = 0; t < RUN_LEN - 1; t++) strobe('0, "R1 R7 partial rerun");
            end
        end

        // R8: reset mid-run needs a fresh full run
        rj_mode = 1'b0;
        for (int t = 0; t < 5; t++) strobe('0, "R1 pre-reset");
        do_reset();
        for (int t = 0; t < RUN_LEN - 1; t++) strobe('0, "R8 post-reset run");
        strobe('0, "R8 R1 post-reset complete");

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule